// File: doc/BRIEF.md
# Serial Stuck-At Fault Simulator

This block grades a set of test patterns against a small combinational netlist. The netlist is a levelized list of one- and two-input gates held in internal registers. For every pattern it first computes the correct response. It then injects each single stuck-at-0 and stuck-at-1 fault in turn, re-evaluates the netlist and compares the primary outputs. A fault is detected when any output differs from the correct response.

The results are kept in three forms:
- a per-fault detected bitmap;
- a fault-by-pattern hit table, read through a combinational port;
- a count of detected faults, shown next to the fixed total.

Patterns arrive over a valid/ready handshake. A one-cycle done pulse marks the end of a run.

An optional dropping mode stops re-simulating faults that an earlier pattern already caught. This shortens later patterns. Evaluation is serial: one pass covers the whole netlist at one gate per clock cycle.

Top module: `stuck_fault_sim`

## Requirements
- R1: Nets are numbered with primary inputs 0..NUM_PI-1 first, then gate g's output as net NUM_PI+g. Fault sites are numbered as follows:
  - site s below NUM_PI+NUM_GATES is the stem of net s;
  - site NUM_PI+NUM_GATES+2g is input pin A of gate g;
  - site NUM_PI+NUM_GATES+2g+1 is input pin B of gate g.

  Fault index f = 2·site + stuck value. `fault_total` reports 2·(NUM_PI+3·NUM_GATES), which is 44 by default.
- R2: Gate g is configured by writing `cfg_op`, `cfg_src_a` and `cfg_src_b` with `cfg_we` while idle. The opcodes are:
  - 0 AND, 1 OR, 2 NAND, 3 NOR;
  - 4 XOR, 5 XNOR;
  - 6 NOT and 7 BUF, which use pin A only.

  Gates are evaluated in index order. Primary output k is net NUM_PI+NUM_GATES-NUM_PO+k, so the outputs are the last NUM_PO gate outputs.
- R3: A stem fault forces the net's value for every reader. A pin fault forces only that one gate input and leaves the driving net untouched.
- R4: For each pattern, the fault-free response is computed first. A fault counts as detected by that pattern exactly when any primary output of the faulty pass differs from the fault-free response.
- R5: `rd_hit` returns, without a clock delay, whether fault `rd_fault` was detected by pattern number `rd_pat` of the last run. Patterns are counted from 0 in order of acceptance.
- R6: `det_map` bit f is set once fault f has been detected by any pattern of the run. `det_cnt` equals the number of set bits, and no bit clears during a run.
- R7: With `drop_en` high at `start`, a fault already detected is not simulated for later patterns. Its table entries for those patterns stay 0, while its bitmap bit stays set.
- R8: A run ends after the pattern accepted with `pat_last` high, or after the MAX_PAT-th pattern. `done` is then high for exactly one cycle, and `det_cnt` and `det_map` hold until the next `start`.
- R9: After reset the block is idle, with `pat_ready`, `done`, `busy`, `det_cnt` and `det_map` all 0. A `start` pulse while idle clears the bitmap, the count and the table, then begins a run.
- R10: `pat_ready` is high only while the block waits for the next pattern. A pattern is taken on a cycle with `pat_valid` and `pat_ready` both high, after which `pat_ready` drops while the pattern is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Gate configuration write strobe |
| cfg_gate | input | GW | Gate index written |
| cfg_op | input | 3 | Gate opcode |
| cfg_src_a | input | NWW | Net feeding pin A |
| cfg_src_b | input | NWW | Net feeding pin B |
| start | input | 1 | Begin a run (idle only) |
| drop_en | input | 1 | Fault dropping for the run, sampled at start |
| pat_valid | input | 1 | Pattern offered |
| pat_ready | output | 1 | Pattern can be taken |
| pat_bits | input | NUM_PI | Primary input values, bit i to net i |
| pat_last | input | 1 | Offered pattern is the run's last |
| det_map | output | NF | Per-fault detected bitmap |
| det_cnt | output | FW | Number of detected faults |
| fault_total | output | FW | Number of modelled faults |
| done | output | 1 | One-cycle end-of-run pulse |
| busy | output | 1 | Run in progress |
| rd_fault | input | FIW | Table read fault index |
| rd_pat | input | PW | Table read pattern index |
| rd_hit | output | 1 | Table entry |

## Verification
The bench sweeps all 16 input patterns through two netlists that together use all eight opcodes. A separate model computes the expected result for every fault and pattern pair, so each table entry shows whether stem and pin injection and the per-output comparison behave correctly. A dropping run over the same patterns separates "detected now" from "first detected now", because only first detections may appear in its table. A short run ended early by the last flag shows that the run length and the count follow the handshake and not MAX_PAT.

// File: rtl/fsim_pkg.sv
`timescale 1ns/1ps
package fsim_pkg;
   typedef enum logic [2:0] {
      OP_AND  = 3'd0,
      OP_OR   = 3'd1,
      OP_NAND = 3'd2,
      OP_NOR  = 3'd3,
      OP_XOR  = 3'd4,
      OP_XNOR = 3'd5,
      OP_NOT  = 3'd6,
      OP_BUF  = 3'd7
   } gate_op_e;

   typedef enum logic [2:0] {
      S_IDLE, S_WAIT, S_LOAD, S_EVAL, S_CMP, S_SEL, S_DONE
   } fsim_state_e;
endpackage

// File: rtl/fsim_gate.sv
`timescale 1ns/1ps
// One gate evaluation with optional forcing of either input pin or the output.
module fsim_gate
   import fsim_pkg::*;
(
   input  gate_op_e op,
   input  logic     in_a,
   input  logic     in_b,
   input  logic     frc_a,
   input  logic     frc_b,
   input  logic     frc_y,
   input  logic     frc_val,
   output logic     y
);
   logic a_eff, b_eff, y_raw;

   always_comb begin
      a_eff = frc_a ? frc_val : in_a;
      b_eff = frc_b ? frc_val : in_b;
      unique case (op)
         OP_AND:  y_raw = a_eff & b_eff;
         OP_OR:   y_raw = a_eff | b_eff;
         OP_NAND: y_raw = ~(a_eff & b_eff);
         OP_NOR:  y_raw = ~(a_eff | b_eff);
         OP_XOR:  y_raw = a_eff ^ b_eff;
         OP_XNOR: y_raw = ~(a_eff ^ b_eff);
         OP_NOT:  y_raw = ~a_eff;
         default: y_raw = a_eff;
      endcase
      y = frc_y ? frc_val : y_raw;
   end
endmodule

// File: rtl/fsim_cov.sv
`timescale 1ns/1ps
// Detected-fault bitmap and running count.
module fsim_cov #(
   parameter int NF = 44,
   localparam int FW  = $clog2(NF + 1),
   localparam int FIW = $clog2(NF)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           set_en,
   input  logic [FIW-1:0] set_idx,
   output logic [NF-1:0]  map,
   output logic [FW-1:0]  cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map <= '0;
         cnt <= '0;
      end else if (clr) begin
         map <= '0;
         cnt <= '0;
      end else if (set_en && !map[set_idx]) begin
         map[set_idx] <= 1'b1;
         cnt          <= cnt + FW'(1);
      end
   end

   // R6
   cnt_matches_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) == $countones(map));

   // R6
   map_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((map & $past(map)) == $past(map)));
endmodule

// File: rtl/fsim_table.sv
`timescale 1ns/1ps
// Fault-by-pattern hit table; KEEP_TABLE=0 removes the storage.
module fsim_table #(
   parameter int NF         = 44,
   parameter int MAX_PAT    = 16,
   parameter bit KEEP_TABLE = 1'b1,
   localparam int FIW = $clog2(NF),
   localparam int PW  = $clog2(MAX_PAT)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           wr_en,
   input  logic [FIW-1:0] wr_fault,
   input  logic [PW-1:0]  wr_pat,
   input  logic [FIW-1:0] rd_fault,
   input  logic [PW-1:0]  rd_pat,
   output logic           rd_hit
);
   generate
      if (KEEP_TABLE) begin : g_store
         logic [MAX_PAT-1:0] tbl_q [NF];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int f = 0; f < NF; f++) tbl_q[f] <= '0;
            end else if (clr) begin
               for (int f = 0; f < NF; f++) tbl_q[f] <= '0;
            end else if (wr_en) begin
               tbl_q[wr_fault][wr_pat] <= 1'b1;
            end
         end

         assign rd_hit = (32'(rd_fault) < NF) ? tbl_q[rd_fault][rd_pat] : 1'b0;
      end else begin : g_none
         logic unused_in;
         assign unused_in = ^{clk, rst_n, clr, wr_en, wr_fault, wr_pat, rd_fault, rd_pat};
         assign rd_hit    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/stuck_fault_sim.sv
`timescale 1ns/1ps
module stuck_fault_sim
   import fsim_pkg::*;
#(
   parameter int NUM_PI     = 4,
   parameter int NUM_GATES  = 6,
   parameter int NUM_PO     = 2,
   parameter int MAX_PAT    = 16,
   parameter bit KEEP_TABLE = 1'b1,
   localparam int NETS  = NUM_PI + NUM_GATES,
   localparam int SITES = NETS + 2 * NUM_GATES,
   localparam int NF    = 2 * SITES,
   localparam int FW    = $clog2(NF + 1),
   localparam int FIW   = $clog2(NF),
   localparam int NWW   = $clog2(NETS),
   localparam int GW    = $clog2(NUM_GATES),
   localparam int PW    = $clog2(MAX_PAT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [GW-1:0]     cfg_gate,
   input  logic [2:0]        cfg_op,
   input  logic [NWW-1:0]    cfg_src_a,
   input  logic [NWW-1:0]    cfg_src_b,
   input  logic              start,
   input  logic              drop_en,
   input  logic              pat_valid,
   output logic              pat_ready,
   input  logic [NUM_PI-1:0] pat_bits,
   input  logic              pat_last,
   output logic [NF-1:0]     det_map,
   output logic [FW-1:0]     det_cnt,
   output logic [FW-1:0]     fault_total,
   output logic              done,
   output logic              busy,
   input  logic [FIW-1:0]    rd_fault,
   input  logic [PW-1:0]     rd_pat,
   output logic              rd_hit
);
   generate
      if (NUM_PI < 1 || NUM_GATES < 2 || NUM_PO < 1 || NUM_PO > NUM_GATES || MAX_PAT < 2) begin : g_bad_cfg
         $error("stuck_fault_sim: illegal parameter combination");
      end
   endgenerate

   // netlist configuration
   gate_op_e       op_q  [NUM_GATES];
   logic [NWW-1:0] sa_q  [NUM_GATES];
   logic [NWW-1:0] sb_q  [NUM_GATES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int g = 0; g < NUM_GATES; g++) begin
            op_q[g] <= OP_BUF;
            sa_q[g] <= '0;
            sb_q[g] <= '0;
         end
      end else if (cfg_we) begin
         op_q[cfg_gate] <= gate_op_e'(cfg_op);
         sa_q[cfg_gate] <= cfg_src_a;
         sb_q[cfg_gate] <= cfg_src_b;
      end
   end

   // run state
   fsim_state_e       state_q;
   logic [NETS-1:0]   nets_q;
   logic [NUM_PO-1:0] golden_q;
   logic [NUM_PI-1:0] pat_q;
   logic              last_q;
   logic              drop_q;
   logic              good_q;
   logic [GW-1:0]     gidx_q;
   logic [FW-1:0]     fcur_q;
   logic [PW-1:0]     pidx_q;
   logic              done_q;

   // current fault decode
   logic [FW-1:0]     site;
   logic              sval;
   logic              inj;
   logic [FW-1:0]     pin_a_site, pin_b_site, stem_y_site;
   logic              gate_y;
   logic [NUM_PO-1:0] po_now;
   logic              po_hit;
   logic              faults_done;
   logic              wr_hit;
   logic              run_clr;

   always_comb begin
      site        = {1'b0, fcur_q[FW-1:1]};
      sval        = fcur_q[0];
      inj         = !good_q;
      pin_a_site  = FW'(NETS) + (FW'(gidx_q) << 1);
      pin_b_site  = pin_a_site + FW'(1);
      stem_y_site = FW'(NUM_PI) + FW'(gidx_q);
      po_now      = nets_q[NETS-1 -: NUM_PO];
      po_hit      = po_now != golden_q;
      faults_done = fcur_q == FW'(NF);
      wr_hit      = (state_q == S_CMP) && !good_q && po_hit;
      run_clr     = (state_q == S_IDLE) && start;
   end

   fsim_gate u_gate (
      .op      (op_q[gidx_q]),
      .in_a    (nets_q[sa_q[gidx_q]]),
      .in_b    (nets_q[sb_q[gidx_q]]),
      .frc_a   (inj && site == pin_a_site),
      .frc_b   (inj && site == pin_b_site),
      .frc_y   (inj && site == stem_y_site),
      .frc_val (sval),
      .y       (gate_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         nets_q   <= '0;
         golden_q <= '0;
         pat_q    <= '0;
         last_q   <= 1'b0;
         drop_q   <= 1'b0;
         good_q   <= 1'b1;
         gidx_q   <= '0;
         fcur_q   <= '0;
         pidx_q   <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: if (start) begin
               drop_q  <= drop_en;
               pidx_q  <= '0;
               state_q <= S_WAIT;
            end
            S_WAIT: if (pat_valid) begin
               pat_q   <= pat_bits;
               last_q  <= pat_last || (pidx_q == PW'(MAX_PAT - 1));
               good_q  <= 1'b1;
               state_q <= S_LOAD;
            end
            S_LOAD: begin
               for (int i = 0; i < NUM_PI; i++)
                  nets_q[i] <= (inj && site == FW'(i)) ? sval : pat_q[i];
               gidx_q  <= '0;
               state_q <= S_EVAL;
            end
            S_EVAL: begin
               nets_q[NWW'(NUM_PI) + NWW'(gidx_q)] <= gate_y;
               if (gidx_q == GW'(NUM_GATES - 1)) state_q <= S_CMP;
               else gidx_q <= gidx_q + GW'(1);
            end
            S_CMP: begin
               if (good_q) begin
                  golden_q <= po_now;
                  good_q   <= 1'b0;
                  fcur_q   <= '0;
               end else begin
                  fcur_q <= fcur_q + FW'(1);
               end
               state_q <= S_SEL;
            end
            S_SEL: begin
               if (faults_done) begin
                  if (last_q) begin
                     done_q  <= 1'b1;
                     state_q <= S_DONE;
                  end else begin
                     pidx_q  <= pidx_q + PW'(1);
                     state_q <= S_WAIT;
                  end
               end else if (drop_q && det_map[fcur_q[FIW-1:0]]) begin
                  fcur_q <= fcur_q + FW'(1);
               end else begin
                  state_q <= S_LOAD;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   fsim_cov #(.NF(NF)) u_cov (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (run_clr),
      .set_en  (wr_hit),
      .set_idx (fcur_q[FIW-1:0]),
      .map     (det_map),
      .cnt     (det_cnt)
   );

   fsim_table #(.NF(NF), .MAX_PAT(MAX_PAT), .KEEP_TABLE(KEEP_TABLE)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (run_clr),
      .wr_en    (wr_hit),
      .wr_fault (fcur_q[FIW-1:0]),
      .wr_pat   (pidx_q),
      .rd_fault (rd_fault),
      .rd_pat   (rd_pat),
      .rd_hit   (rd_hit)
   );

   assign pat_ready   = state_q == S_WAIT;
   assign done        = done_q;
   assign busy        = state_q != S_IDLE;
   assign fault_total = FW'(NF);

   // R10
   accept_moves_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pat_valid && pat_ready |=> !pat_ready && busy);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> $stable(det_cnt) && $stable(det_map));

   // R7
   no_resim_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_LOAD) && !good_q && drop_q |-> !det_map[fcur_q[FIW-1:0]]);
endmodule

// File: tb/stuck_fault_sim_bench.sv
`timescale 1ns/1ps
module stuck_fault_sim_bench;
   localparam int NPI = 4, NG = 6, NPO = 2, MP = 16;
   localparam int NETS = NPI + NG, NF = 2 * (NETS + 2 * NG);

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_gate = '0, cfg_op = '0;
   logic [3:0] cfg_src_a = '0, cfg_src_b = '0;
   logic       start = 1'b0, drop_en = 1'b0, pat_valid = 1'b0, pat_last = 1'b0;
   logic [3:0] pat_bits = '0;
   logic       pat_ready, done, busy, rd_hit;
   logic [NF-1:0] det_map;
   logic [5:0] det_cnt, fault_total;
   logic [5:0] rd_fault = '0;
   logic [3:0] rd_pat = '0;

   int n_chk = 0, n_bad = 0;
   int bop [NG], bsa [NG], bsb [NG];
   bit hit [NF][MP];

   always #2 clk = ~clk;

   stuck_fault_sim u_stuck_fault_sim (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_gate(cfg_gate), .cfg_op(cfg_op),
      .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b), .start(start), .drop_en(drop_en),
      .pat_valid(pat_valid), .pat_ready(pat_ready), .pat_bits(pat_bits), .pat_last(pat_last),
      .det_map(det_map), .det_cnt(det_cnt), .fault_total(fault_total), .done(done),
      .busy(busy), .rd_fault(rd_fault), .rd_pat(rd_pat), .rd_hit(rd_hit));

   task automatic chk(string req, longint act, longint exp, string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit gfun(int op, bit a, bit b);
      case (op)
         0: return a & b;
         1: return a | b;
         2: return ~(a & b);
         3: return ~(a | b);
         4: return a ^ b;
         5: return ~(a ^ b);
         6: return ~a;
         default: return a;
      endcase
   endfunction

   // Reference response; fault < 0 means fault-free (R1, R3 numbering)
   function automatic int model(int p, int fault);
      bit v [NETS];
      int st = (fault >= 0) ? fault / 2 : -1;
      bit sv = (fault >= 0) ? bit'(fault % 2) : 1'b0;
      for (int i = 0; i < NPI; i++) v[i] = (st == i) ? sv : bit'((p >> i) & 1);
      for (int g = 0; g < NG; g++) begin
         bit a = v[bsa[g]], b = v[bsb[g]], y;
         if (st == NETS + 2 * g)     a = sv;
         if (st == NETS + 2 * g + 1) b = sv;
         y = gfun(bop[g], a, b);
         if (st == NPI + g) y = sv;
         v[NPI + g] = y;
      end
      return {30'd0, v[NETS - 1], v[NETS - 2]};
   endfunction

   task automatic load_net(int set);
      if (set == 0) begin
         bop = '{0, 3, 4, 6, 1, 2}; bsa = '{0, 2, 4, 2, 6, 6}; bsb = '{1, 3, 5, 0, 7, 3};
      end else begin
         bop = '{5, 7, 0, 2, 3, 4}; bsa = '{0, 2, 4, 1, 6, 5}; bsb = '{1, 0, 5, 3, 7, 3};
      end
      for (int g = 0; g < NG; g++) begin
         @(negedge clk);
         cfg_we = 1'b1; cfg_gate = 3'(g); cfg_op = 3'(bop[g]);
         cfg_src_a = 4'(bsa[g]); cfg_src_b = 4'(bsb[g]);
      end
      @(negedge clk) cfg_we = 1'b0;
      for (int f = 0; f < NF; f++)
         for (int p = 0; p < MP; p++)
            hit[f][p] = model(p, f) != model(p, -1);
   endtask

   task automatic run(int npat, bit drop);
      logic [5:0] cnt_at_done;
      @(negedge clk) begin start = 1'b1; drop_en = drop; end
      @(negedge clk) start = 1'b0;
      for (int p = 0; p < npat; p++) begin
         while (!pat_ready) @(negedge clk);
         pat_bits = 4'(p); pat_last = (p == npat - 1); pat_valid = 1'b1;
         @(negedge clk) pat_valid = 1'b0;
         if (p == 0) chk("R10", pat_ready, 0, "ready after accept");
      end
      while (!done) @(negedge clk);
      cnt_at_done = det_cnt;
      @(negedge clk);
      chk("R8", done, 0, "done one cycle");
      chk("R8", det_cnt, cnt_at_done, "count holds");
      chk("R9", busy, 0, "idle after run");
   endtask

   task automatic check_results(int npat, bit drop, string tag);
      int exp_cnt = 0;
      for (int f = 0; f < NF; f++) begin
         int first = -1;
         for (int p = 0; p < npat; p++) if (hit[f][p] && first < 0) first = p;
         if (first >= 0) exp_cnt++;
         chk("R6", det_map[f], first >= 0, {tag, " map bit"});
         for (int p = 0; p < npat; p++) begin
            rd_fault = 6'(f); rd_pat = 4'(p); #0.5;
            if (drop) chk("R7", rd_hit, hit[f][p] && first == p, {tag, " dropped table"});
            else      chk("R5", rd_hit, hit[f][p], {tag, " table R4 R3"});
         end
      end
      chk("R6", det_cnt, exp_cnt, {tag, " count"});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", pat_ready, 0, "reset ready");
      chk("R9", done, 0, "reset done");
      chk("R9", busy, 0, "reset busy");
      chk("R9", det_cnt, 0, "reset count");
      chk("R9", det_map == '0, 1, "reset map");
      chk("R1", fault_total, NF, "total");

      load_net(0);                       // AND NOR XOR NOT OR NAND (R2)
      run(MP, 1'b0); check_results(MP, 1'b0, "net0 full");
      run(MP, 1'b1); check_results(MP, 1'b1, "net0 drop");
      run(3, 1'b0);  check_results(3, 1'b0, "net0 short R8");
      load_net(1);                       // XNOR BUF AND NAND NOR XOR (R2)
      run(MP, 1'b0); check_results(MP, 1'b0, "net1 full");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule